// File: doc/BRIEF.md
# Timer Interrupt Enable and Status Register

This block holds the interrupt control and status of a group of timer channels in one register. The low field holds one enable bit per channel, which software writes directly. The next field holds one sticky status bit per channel. A channel's expiry pulse always sets its status bit. Software clears a status bit by writing a one to it.

Each channel has one level interrupt line. The line rises on an expiry only when that channel's enable bit is set in the same cycle. It then stays high until software clears the channel's status bit. Changing the enable bit later neither raises nor drops a line that is already settled. When an expiry and a clearing write reach the same status bit in the same cycle, the expiry wins. All state is registered, so a write or a pulse shows on the outputs after the next rising clock edge.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: On a write, bits [4:0] of the write data replace the enable field. Without a write the enable field holds.
- R2: Readback bit n is channel n's enable bit, and readback bit 5+n is channel n's status bit.
- R3: An expiry pulse on channel n sets status bit 5+n, whether or not the channel is enabled.
- R4: An expiry raises channel n's line in the next cycle only if enable bit n is set in the cycle of the expiry. Setting the enable bit afterwards does not raise the line.
- R5: Writing a one to status bit 5+n clears it. Writing a zero leaves it unchanged.
- R6: A line falls in the cycle after a write clears its status bit. A line holds its level when only its enable bit changes.
- R7: After reset the readback value and all lines are zero.
- R8: When an expiry and a clearing write hit the same status bit in the same cycle, the status bit stays set.
- R9: Readback bits above bit 9 are always zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| expire_i | input | 5 | Expiry pulses, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data |
| rdata_o | output | 32 | Register readback value |
| irq_o | output | 5 | Level interrupt lines, one per channel |

## Verification
The assertions assume that the expiry pulses and the write strobe are synchronous to the clock and hold a known value at every rising edge. They also assume that a write and an expiry may coincide on any channel. The stimulus drives all inputs on the falling edge and returns them to idle afterwards. It covers enabled and disabled expiries, late enables, clears, coincident set and clear, and writes that set the upper data bits.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  parameter int unsigned CH_NUM_DEF = 5;
  parameter int unsigned DATA_W_DEF = 32;

  typedef struct packed {
    logic status;
    logic irq;
  } chan_state_t;
endpackage

// File: rtl/tmr_irq_en_reg.sv
module tmr_irq_en_reg #(
  parameter int unsigned CH_NUM = tmr_irq_pkg::CH_NUM_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_NUM-1:0] wr_en_bits_i,
  output logic [CH_NUM-1:0] en_o
);
  logic [CH_NUM-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (wr_en_i) en_q <= wr_en_bits_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/tmr_irq_chan.sv
module tmr_irq_chan
  import tmr_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  input  logic en_i,
  output logic status_o,
  output logic irq_o
);
  chan_state_t st_q, st_d;
  logic        drop;

  // line falls only on a real 1->0 status transition; set beats clear
  assign drop = clr_i & st_q.status & ~expire_i;

  always_comb begin
    st_d = st_q;
    if (expire_i)   st_d.status = 1'b1;
    else if (clr_i) st_d.status = 1'b0;
    if (expire_i && en_i) st_d.irq = 1'b1;
    else if (drop)        st_d.irq = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign status_o = st_q.status;
  assign irq_o    = st_q.irq;
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int unsigned CH_NUM = tmr_irq_pkg::CH_NUM_DEF,
  parameter int unsigned DATA_W = tmr_irq_pkg::DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CH_NUM-1:0] expire_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CH_NUM-1:0] irq_o
);
  localparam int unsigned STAT_LSB = CH_NUM;
  localparam int unsigned USED_W   = 2 * CH_NUM;

  logic [CH_NUM-1:0] en;
  logic [CH_NUM-1:0] status;
  logic [CH_NUM-1:0] clr;

  assign clr = wr_en_i ? wr_data_i[STAT_LSB +: CH_NUM] : '0;

  tmr_irq_en_reg #(.CH_NUM(CH_NUM)) u_en (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_en_bits_i (wr_data_i[CH_NUM-1:0]),
    .en_o         (en)
  );

  for (genvar n = 0; n < CH_NUM; n++) begin : g_ch
    tmr_irq_chan u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .expire_i (expire_i[n]),
      .clr_i    (clr[n]),
      .en_i     (en[n]),
      .status_o (status[n]),
      .irq_o    (irq_o[n])
    );
  end

  if (DATA_W > USED_W) begin : g_pad
    assign rdata_o = {{(DATA_W-USED_W){1'b0}}, status, en};
  end else begin : g_nopad
    assign rdata_o = {status, en};
  end
endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk #(
  parameter int unsigned CH_NUM = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CH_NUM-1:0] expire_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [CH_NUM-1:0] irq_o
);
  localparam int unsigned USED_W = 2 * CH_NUM;

  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rdata_o[CH_NUM-1:0] == $past(wr_data_i[CH_NUM-1:0])); // R1

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rdata_o[CH_NUM-1:0])); // R1

  if (DATA_W > USED_W) begin : g_up
    AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdata_o[DATA_W-1:USED_W] == '0); // R9
  end

  for (genvar n = 0; n < CH_NUM; n++) begin : g_ch
    AST_EXPIRE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_i[n] |=> rdata_o[CH_NUM+n]); // R3
    AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!irq_o[n] && !(expire_i[n] && rdata_o[n])) |=> !irq_o[n]); // R4
    AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expire_i[n] && rdata_o[n]) |=> irq_o[n]); // R4
    AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_data_i[CH_NUM+n] && !expire_i[n]) |=> !rdata_o[CH_NUM+n]); // R5
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[n] |-> rdata_o[CH_NUM+n]); // R6
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expire_i[n] && wr_en_i && wr_data_i[CH_NUM+n]) |=> rdata_o[CH_NUM+n]); // R8
  end
endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk #(.CH_NUM(CH_NUM), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .expire_i  (expire_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o)
);

// File: tb/tb_tmr_irq_ctrl.sv
module tb_tmr_irq_ctrl;
  localparam int CH = 5;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [CH-1:0] expire_i = '0;
  logic          wr_en_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rdata_o;
  logic [CH-1:0] irq_o;

  tmr_irq_ctrl #(.CH_NUM(CH), .DATA_W(DW)) dut (.*);

  always #10 clk_i = ~clk_i;

  typedef struct {
    logic [DW-1:0] rd;
    logic [CH-1:0] irq;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [CH-1:0] m_en = '0, m_st = '0, m_irq = '0;

  task automatic check(input string tag, input logic [DW-1:0] rd, input logic [CH-1:0] irq,
                       input logic [DW-1:0] erd, input logic [CH-1:0] eirq);
    n_chk++;
    if (rd !== erd || irq !== eirq) begin
      n_fail++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", tag, rd, irq, erd, eirq);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the predicted outputs
  task automatic step(input logic [CH-1:0] ex, input logic wr, input logic [DW-1:0] d,
                      input string tag);
    logic [CH-1:0] clr;
    exp_t e;
    @(negedge clk_i);
    expire_i  = ex;
    wr_en_i   = wr;
    wr_data_i = d;
    clr   = wr ? d[2*CH-1:CH] : '0;
    m_irq = (m_irq & ~(clr & m_st & ~ex)) | (ex & m_en);
    m_st  = ex | (m_st & ~clr);
    if (wr) m_en = d[CH-1:0];
    e.rd  = {{(DW-2*CH){1'b0}}, m_st, m_en};
    e.irq = m_irq;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, rdata_o, irq_o, e.rd, e.irq);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk_i);
    #5;
    check("R7 reset", rdata_o, irq_o, '0, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step('0, 1'b1, 32'hFFFF_FC05, "R1 R9 enable write, upper bits dropped");
    step('1, 1'b0, '0, "R3 R4 R2 expire all, lines on enabled channels only");
    step('0, 1'b1, 32'h0000_001F, "R4 R6 late enable raises nothing");
    step('0, 1'b0, '0, "R1 enable holds without write");
    step('0, 1'b1, 32'h0000_003F, "R5 R6 clear status ch0 drops line");
    step('0, 1'b1, 32'h0000_0000, "R5 R6 zero write keeps status, disable keeps line");
    step(5'b00010, 1'b1, 32'h0000_0040, "R8 set wins over clear ch1");
    step('0, 1'b1, 32'h0000_03FF, "R5 R6 clear all");
    step('0, 1'b1, 32'h0000_0010, "R1 enable ch4");
    step(5'b10000, 1'b1, 32'h0000_0210, "R8 R4 set wins with enable, line rises");
    step('0, 1'b1, 32'hFFFF_FE10, "R6 R9 clear ch4 with upper bits set");
    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[4:0] & {5{lfsr[11]}}, lfsr[7],
           {lfsr[15:8], 14'h0, lfsr[9:0]}, "R2 R3 R4 R5 R6 R8 mixed pattern");
    end
    step('0, 1'b0, '0, "R6 idle");
    repeat (3) @(posedge clk_i);
    #5;
    finish_run();
  end
endmodule